// File: doc/BRIEF.md
# I/Q Word Deinterleaver for a Dual Converter Pair

This block takes a single shared data bus on which an in-phase (I) word and a quadrature (Q) word arrive one after the other in every sample period. It splits that stream into two parallel code outputs, one for each of two converters. The block runs from a clock at twice the sample rate. An internal slot bit alternates between the I slot and the Q slot, and it returns to the I slot after reset and after standby.

On an I-slot edge the bus word is captured into a holding register. On the following Q-slot edge the held I word and the Q word on the bus are loaded into the two output registers together. Both channel outputs therefore change on the same edge, and each output pair stays in place for a full sample period. Codes are straight binary: 0 is the lowest code, 2^(CODE_W-1) is midscale (512 for 10 bits), and 2^CODE_W-1 is the highest code.

An active-high standby input idles both outputs at midscale and drops any half-received pair. A pair-valid flag shows that the outputs carry a completed pair.

Top module: `iq_deinterleave`

## Requirements
- R1: A synchronous active-high reset sets both outputs to midscale (512 for CODE_W=10), drives pair_valid low, clears the holding register and puts the slot bit in the I slot.
- R2: The first clock edge after reset or standby is released is an I slot. After that, slots alternate I, Q, I, Q on every edge.
- R3: On a Q-slot edge without standby, i_code takes the word that was on the bus at the preceding I-slot edge, and q_code takes the word on the bus at this edge. Both load on the same edge.
- R4: On an I-slot edge, neither output changes. Each output pair is held for one full sample period (two clocks).
- R5: Codes pass through unchanged as straight binary over the full range 0 to 2^CODE_W-1, with no offset or inversion.
- R6: Standby is active high. The edge that samples standby high sets both outputs to midscale and pair_valid low, and they stay there while standby remains high.
- R7: Standby drops an I word that has been captured but not yet paired. After release, the first pair loaded comes only from words sent after the release.
- R8: pair_valid rises on the edge that loads a pair. It stays high for at least the following I slot, so that it covers one sample period per pair. It stays low after reset or standby until the first pair is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Idle request, active high |
| bus_word | input | CODE_W | Shared bus carrying I then Q words |
| i_code | output | CODE_W | In-phase channel code |
| q_code | output | CODE_W | Quadrature channel code |
| pair_valid | output | 1 | High once a completed pair is on the outputs |

## Verification
The main sweep sends all 1024 I codes, each paired with a Q code computed from it. This shows whether the two channels are swapped or shifted by a slot, and whether any bit is lost at either end of the range. Patterns of constant midscale and of alternating extremes show whether anything leaks from one pair into the next. A check in the middle of every pair shows whether an output moves on the I-slot edge. A standby asserted after an I word has been captured, followed by a fresh pair, shows whether the stale I word is dropped and the slot realigned. It also shows whether pair_valid stays low until new data arrives.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic {SLOT_I = 1'b0, SLOT_Q = 1'b1} slot_e;

  // Midscale code for a straight-binary word of the given width.
  function automatic int unsigned midscale(int unsigned width);
    return 32'd1 << (width - 1);
  endfunction
endpackage

// File: rtl/iqd_slot_ctr.sv
module iqd_slot_ctr
  import iqd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  standby,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (rst || standby) slot <= SLOT_I;
    else                slot <= (slot == SLOT_I) ? SLOT_Q : SLOT_I;
  end
endmodule

// File: rtl/iqd_hold_reg.sv
module iqd_hold_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/iqd_pair_reg.sv
module iqd_pair_reg
  import iqd_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              load,
  input  logic [CODE_W-1:0] d   [NCH],
  output logic [CODE_W-1:0] q   [NCH],
  output logic              valid
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || standby) q[c] <= MID;
      else if (load)      q[c] <= d[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || standby) valid <= 1'b0;
    else if (load)      valid <= 1'b1;
  end
endmodule

// File: rtl/iq_deinterleave.sv
module iq_deinterleave
  import iqd_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic [CODE_W-1:0] bus_word,
  output logic [CODE_W-1:0] i_code,
  output logic [CODE_W-1:0] q_code,
  output logic              pair_valid
);
  localparam int NCH = 2;

  slot_e             slot;
  logic              capture_i;
  logic              transfer_pair;
  logic [CODE_W-1:0] held_i;
  logic [CODE_W-1:0] pair_d [NCH];
  logic [CODE_W-1:0] pair_q [NCH];

  assign capture_i     = (slot == SLOT_I) && !standby;
  assign transfer_pair = (slot == SLOT_Q) && !standby;

  iqd_slot_ctr u_slot (
    .clk(clk), .rst(rst), .standby(standby), .slot(slot)
  );

  iqd_hold_reg #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst(rst), .clear(standby), .capture(capture_i),
    .d(bus_word), .q(held_i)
  );

  assign pair_d[0] = held_i;
  assign pair_d[1] = bus_word;

  iqd_pair_reg #(.CODE_W(CODE_W), .NCH(NCH)) u_pair (
    .clk(clk), .rst(rst), .standby(standby), .load(transfer_pair),
    .d(pair_d), .q(pair_q), .valid(pair_valid)
  );

  assign i_code = pair_q[0];
  assign q_code = pair_q[1];
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker
  import iqd_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic [CODE_W-1:0] bus_word,
  input logic [CODE_W-1:0] i_code,
  input logic [CODE_W-1:0] q_code,
  input logic              pair_valid,
  input slot_e             slot,
  input logic              transfer_pair
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (i_code == MID) && (q_code == MID) && !pair_valid && (slot == SLOT_I));

  a_r2_slot_toggle: assert property (@(posedge clk) disable iff (rst)
    !standby |=> (slot != $past(slot)));

  a_r3_pair_load: assert property (@(posedge clk) disable iff (rst)
    transfer_pair |=> (i_code == $past(bus_word, 2)) && (q_code == $past(bus_word)));

  a_r4_hold_on_i: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_I && !standby) |=> $stable(i_code) && $stable(q_code));

  a_r6_standby_idle: assert property (@(posedge clk) disable iff (rst)
    standby |=> (i_code == MID) && (q_code == MID) && !pair_valid);

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pair_valid) |-> $past(transfer_pair));
endmodule

bind iq_deinterleave iqd_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .standby(standby), .bus_word(bus_word),
  .i_code(i_code), .q_code(q_code), .pair_valid(pair_valid),
  .slot(slot), .transfer_pair(transfer_pair)
);

// File: tb/iq_deinterleave_tb_top.sv
module iq_deinterleave_tb_top;
  localparam int W   = 10;
  localparam int MID = 512;
  localparam int TOP = 1023;

  logic         clk = 1'b0;
  logic         rst, standby;
  logic [W-1:0] bus;
  logic [W-1:0] i_code, q_code;
  logic         pair_valid;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_i, exp_q;
  logic         exp_v;

  always #2 clk = ~clk;

  iq_deinterleave #(.CODE_W(W)) dut_i (
    .clk(clk), .rst(rst), .standby(standby), .bus_word(bus),
    .i_code(i_code), .q_code(q_code), .pair_valid(pair_valid)
  );

  task automatic check(input string req);
    checks++;
    if (i_code !== exp_i || q_code !== exp_q || pair_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: got i=%0d q=%0d v=%0b expected i=%0d q=%0d v=%0b",
               req, i_code, q_code, pair_valid, exp_i, exp_q, exp_v);
    end
  endtask

  // Starts on a negedge just before an I-slot edge.
  task automatic send_pair(input int iv, input int qv, input string req);
    bus = W'(iv);
    @(negedge clk);
    check("R4 hold through I slot");
    bus = W'(qv);
    @(negedge clk);
    exp_i = W'(iv); exp_q = W'(qv); exp_v = 1'b1;
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; standby = 1'b0; bus = '0;
    exp_i = W'(MID); exp_q = W'(MID); exp_v = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst = 1'b0;

    // R2/R3/R5 sweep over every I code
    for (int k = 0; k <= TOP; k++)
      send_pair(k, (k * 37 + 512) % 1024, "R3 R5 sweep");

    // R5 extremes and midscale
    send_pair(0, TOP, "R5 extremes low/high");
    send_pair(TOP, 0, "R5 extremes high/low");
    send_pair(MID, MID, "R5 midscale");

    // R1 reset in the middle of a pair
    bus = W'(77);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_i = W'(MID); exp_q = W'(MID); exp_v = 1'b0;
    check("R1 reset mid-stream");
    send_pair(5, 6, "R2 first pair after reset");

    // R6/R7 standby after an I word has been captured
    bus = W'(111);
    @(negedge clk);
    standby = 1'b1; bus = W'(222);
    exp_i = W'(MID); exp_q = W'(MID); exp_v = 1'b0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R6 standby idle");
      bus = W'(333 + s);
    end
    standby = 1'b0;
    send_pair(300, 400, "R7 fresh pair after standby");
    send_pair(1, 2, "R8 valid continues");

    // R6 standby asserted right on an I slot
    standby = 1'b1;
    @(negedge clk);
    exp_i = W'(MID); exp_q = W'(MID); exp_v = 1'b0;
    check("R6 standby on I slot");
    standby = 1'b0;
    send_pair(1000, 24, "R8 valid after release");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule